// File: doc/BRIEF.md
# Paged NIC Control Register Bank

This block is the byte-wide control register bank of a network interface controller. Software reaches it through a 4-bit register index, separate read and write strobes, and an 8-bit data path. Index 0 is always the command register. Bits 7:6 of that register choose which of four pages the other fifteen indices address. On the local page (page 0), a write and a read at the same index reach different registers. Most page-0 registers can only be written. On the address page (page 1), every index holds a byte that can be read back: the station address, the current-page pointer and the multicast filter.

The stored values leave the block as parallel outputs, which the transmit, receive and DMA engines consume. The access side has no streaming data, so there is no valid/ready handshake and no back-pressure. A strobe is accepted in the cycle it is high. Pages 2 and 3 are not implemented. An access to a non-zero index while one of them is selected is flagged.

Top module: `nic_reg_bank`

## Requirements
- R1: A write at index 0 loads the command register on the clock edge where the write strobe is high, in every page. Reading index 0 returns it in every page. Its bits 7:6 select the page. Its fields are bit 0 stop, bit 1 start, bit 2 transmit, and bits 5:3 remote-DMA command.
- R2: After reset, the command register is 0x01 (stop set) and the interrupt status is 0x80 (bit 7 = reset). Every other register is 0x00.
- R3: On page 0, a write at each index 1..15 loads, in order: ring start, ring stop, boundary, transmit page, transmit count low, transmit count high, interrupt status, remote address low, remote address high, remote count low, remote count high, receive config, transmit config, data config, interrupt mask. Each one is presented on its own output.
- R4: On page 0, reading index 3 returns the boundary and reading index 7 returns the interrupt status. Every other non-zero page-0 index reads 0x00.
- R5: On page 1, indices 1..6 are station-address bytes, where index k drives station_addr bits [8(k-1)+7 : 8(k-1)]. Index 7 is the current-page pointer. Indices 8..15 are filter bytes, where index 8+j drives mcast_filter bits [8j+7 : 8j]. All of them read back what was last written.
- R6: A transmit count low write replaces tx_count[7:0] and a transmit count high write replaces tx_count[15:8]. The other half keeps its value. Remote address and remote count split the same way, with index 8 low and 9 high, and index 10 low and 11 high.
- R7: A write to one page leaves every register of the other page unchanged.
- R8: With page 2 or 3 selected, a non-zero index reads 0x00 and writes change no register. page_err is high for exactly the one cycle after each such read or write strobe.
- R9: rd_data is combinational from the index and the current page, with no wait cycle. page_err stays low for accesses to index 0 and for accesses on pages 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 4 | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational |
| page_err | output | 1 | One-cycle pulse after an access to an unimplemented page |
| cmd | output | 8 | Command register |
| ring_start | output | 8 | Receive ring start page |
| ring_stop | output | 8 | Receive ring stop page |
| boundary | output | 8 | Boundary pointer |
| tx_page | output | 8 | Transmit start page |
| tx_count | output | 16 | Transmit byte count |
| int_status | output | 8 | Interrupt status (0 rx, 1 tx, 2 rx error, 3 tx error, 4 overwrite, 5 counter overflow, 6 remote DMA done, 7 reset) |
| remote_addr | output | 16 | Remote DMA start address |
| remote_count | output | 16 | Remote DMA byte count |
| rx_cfg | output | 8 | Receive configuration |
| tx_cfg | output | 8 | Transmit configuration |
| data_cfg | output | 8 | Data configuration |
| int_mask | output | 8 | Interrupt mask |
| station_addr | output | 48 | Station address bytes |
| cur_page_ptr | output | 8 | Current receive page pointer |
| mcast_filter | output | 64 | Multicast filter bytes |

## Verification
The bench selects each of the four pages and writes a distinct value to all fifteen non-zero indices. Because every value differs, a write that lands at the wrong index or on the wrong page shows up as a mismatch. It then reads every index on every page. This tells apart the write-only page-0 view, the page-1 read-back view, and the zero view of the unimplemented pages. A separate sequence writes the two halves of the transmit count in alternating order, which exposes any write that clobbers the other byte. Read strobes on every page check that page_err pulses only for the unimplemented pages.

// File: rtl/nicreg_pkg.sv
package nicreg_pkg;

  localparam int DATA_W    = 8;
  localparam int IDX_W     = 4;
  localparam int NUM_SLOTS = 1 << IDX_W;
  localparam int STA_BYTES = 6;
  localparam int FLT_BYTES = 8;

  typedef enum logic [1:0] {
    PG_LOCAL = 2'd0,
    PG_ADDR  = 2'd1,
    PG_RSV2  = 2'd2,
    PG_RSV3  = 2'd3
  } page_e;

  // Local page slot indices (write view)
  localparam int S_RING_START = 1;
  localparam int S_RING_STOP  = 2;
  localparam int S_BOUNDARY   = 3;
  localparam int S_TX_PAGE    = 4;
  localparam int S_TXCNT_LO   = 5;
  localparam int S_TXCNT_HI   = 6;
  localparam int S_INT_STAT   = 7;
  localparam int S_RADDR_LO   = 8;
  localparam int S_RADDR_HI   = 9;
  localparam int S_RCNT_LO    = 10;
  localparam int S_RCNT_HI    = 11;
  localparam int S_RX_CFG     = 12;
  localparam int S_TX_CFG     = 13;
  localparam int S_DATA_CFG   = 14;
  localparam int S_INT_MASK   = 15;

  // Address page slot indices
  localparam int S_STA_BASE   = 1;
  localparam int S_CUR_PAGE   = 7;
  localparam int S_FLT_BASE   = 8;

  // Local page indices that return stored data on a read
  localparam logic [NUM_SLOTS-1:0] LOCAL_READ_MASK =
    NUM_SLOTS'((1 << S_BOUNDARY) | (1 << S_INT_STAT));

  localparam logic [DATA_W-1:0] CMD_RST_VAL = 8'h01;
  localparam logic [DATA_W-1:0] INT_RST_VAL = 8'h80;

  localparam int PAGE_MSB = DATA_W - 1;
  localparam int PAGE_LSB = DATA_W - 2;

endpackage

// File: rtl/nicreg_decode.sv
module nicreg_decode
  import nicreg_pkg::*;
#(
  parameter int IW    = IDX_W,
  parameter int SLOTS = NUM_SLOTS
) (
  input  page_e            page,
  input  logic [IW-1:0]    idx,
  input  logic             rd_en,
  input  logic             wr_en,
  output logic             wr_cmd,
  output logic [SLOTS-1:0] wr_local,
  output logic [SLOTS-1:0] wr_addr,
  output logic             bad_access
);
  logic [SLOTS-1:0] onehot;
  logic             banked;

  always_comb begin
    onehot     = {{(SLOTS-1){1'b0}}, 1'b1} << idx;
    banked     = (idx != '0);
    wr_cmd     = wr_en && !banked;
    wr_local   = (wr_en && banked && page == PG_LOCAL) ? onehot : '0;
    wr_addr    = (wr_en && banked && page == PG_ADDR)  ? onehot : '0;
    bad_access = (rd_en || wr_en) && banked &&
                 (page == PG_RSV2 || page == PG_RSV3);
  end
endmodule

// File: rtl/nicreg_bank.sv
module nicreg_bank
  import nicreg_pkg::*;
#(
  parameter int              DW       = DATA_W,
  parameter int              SLOTS    = NUM_SLOTS,
  parameter int              HOT_SLOT = 0,
  parameter logic [DW-1:0]   HOT_VAL  = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0]          wr_sel,
  input  logic [DW-1:0]             wr_data,
  output logic [SLOTS-1:0][DW-1:0]  q
);
  assign q[0] = '0;

  for (genvar k = 1; k < SLOTS; k++) begin : g_slot
    localparam logic [DW-1:0] RST_VAL = (k == HOT_SLOT) ? HOT_VAL : '0;
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)         r <= RST_VAL;
      else if (wr_sel[k]) r <= wr_data;
    end
    assign q[k] = r;
  end
endmodule

// File: rtl/nicreg_rdmux.sv
module nicreg_rdmux
  import nicreg_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int IW    = IDX_W,
  parameter int SLOTS = NUM_SLOTS
) (
  input  page_e                     page,
  input  logic [IW-1:0]             idx,
  input  logic [DW-1:0]             cmd,
  input  logic [SLOTS-1:0][DW-1:0]  local_q,
  input  logic [SLOTS-1:0][DW-1:0]  addr_q,
  output logic [DW-1:0]             rd_data
);
  always_comb begin
    rd_data = '0;
    if (idx == '0) begin
      rd_data = cmd;
    end else begin
      unique case (page)
        PG_LOCAL: rd_data = LOCAL_READ_MASK[idx] ? local_q[idx] : '0;
        PG_ADDR:  rd_data = addr_q[idx];
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/nic_reg_bank.sv
module nic_reg_bank
  import nicreg_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int IW  = IDX_W,
  parameter int STA = STA_BYTES,
  parameter int FLT = FLT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     reg_idx,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              page_err,
  output logic [DW-1:0]     cmd,
  output logic [DW-1:0]     ring_start,
  output logic [DW-1:0]     ring_stop,
  output logic [DW-1:0]     boundary,
  output logic [DW-1:0]     tx_page,
  output logic [2*DW-1:0]   tx_count,
  output logic [DW-1:0]     int_status,
  output logic [2*DW-1:0]   remote_addr,
  output logic [2*DW-1:0]   remote_count,
  output logic [DW-1:0]     rx_cfg,
  output logic [DW-1:0]     tx_cfg,
  output logic [DW-1:0]     data_cfg,
  output logic [DW-1:0]     int_mask,
  output logic [STA*DW-1:0] station_addr,
  output logic [DW-1:0]     cur_page_ptr,
  output logic [FLT*DW-1:0] mcast_filter
);
  localparam int SLOTS = 1 << IW;

  page_e                    page;
  logic                     wr_cmd;
  logic [SLOTS-1:0]         wr_local;
  logic [SLOTS-1:0]         wr_addr;
  logic                     bad_access;
  logic [SLOTS-1:0][DW-1:0] local_q;
  logic [SLOTS-1:0][DW-1:0] addr_q;
  logic [DW-1:0]            cmd_q;

  assign page = page_e'(cmd_q[DW-1 -: 2]);

  nicreg_decode #(.IW(IW), .SLOTS(SLOTS)) u_dec (
    .page       (page),
    .idx        (reg_idx),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wr_cmd     (wr_cmd),
    .wr_local   (wr_local),
    .wr_addr    (wr_addr),
    .bad_access (bad_access)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_RST_VAL;
      page_err <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= wr_data;
      page_err <= bad_access;
    end
  end

  nicreg_bank #(.DW(DW), .SLOTS(SLOTS), .HOT_SLOT(S_INT_STAT),
                .HOT_VAL(INT_RST_VAL)) u_local (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_local),
    .wr_data (wr_data),
    .q       (local_q)
  );

  nicreg_bank #(.DW(DW), .SLOTS(SLOTS), .HOT_SLOT(0),
                .HOT_VAL('0)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_addr),
    .wr_data (wr_data),
    .q       (addr_q)
  );

  nicreg_rdmux #(.DW(DW), .IW(IW), .SLOTS(SLOTS)) u_rd (
    .page    (page),
    .idx     (reg_idx),
    .cmd     (cmd_q),
    .local_q (local_q),
    .addr_q  (addr_q),
    .rd_data (rd_data)
  );

  assign cmd          = cmd_q;
  assign ring_start   = local_q[S_RING_START];
  assign ring_stop    = local_q[S_RING_STOP];
  assign boundary     = local_q[S_BOUNDARY];
  assign tx_page      = local_q[S_TX_PAGE];
  assign tx_count     = {local_q[S_TXCNT_HI], local_q[S_TXCNT_LO]};
  assign int_status   = local_q[S_INT_STAT];
  assign remote_addr  = {local_q[S_RADDR_HI], local_q[S_RADDR_LO]};
  assign remote_count = {local_q[S_RCNT_HI], local_q[S_RCNT_LO]};
  assign rx_cfg       = local_q[S_RX_CFG];
  assign tx_cfg       = local_q[S_TX_CFG];
  assign data_cfg     = local_q[S_DATA_CFG];
  assign int_mask     = local_q[S_INT_MASK];
  assign cur_page_ptr = addr_q[S_CUR_PAGE];

  for (genvar j = 0; j < STA; j++) begin : g_sta
    assign station_addr[j*DW +: DW] = addr_q[S_STA_BASE + j];
  end

  for (genvar j = 0; j < FLT; j++) begin : g_flt
    assign mcast_filter[j*DW +: DW] = addr_q[S_FLT_BASE + j];
  end
endmodule

// File: rtl/nicreg_checker.sv
module nicreg_checker #(
  parameter int DW    = 8,
  parameter int IW    = 4,
  parameter int SLOTS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IW-1:0]     reg_idx,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic [DW-1:0]     rd_data,
  input logic              page_err,
  input logic [DW-1:0]     cmd,
  input logic [2*DW-1:0]   tx_count,
  input logic              wr_cmd,
  input logic [SLOTS-1:0]  wr_local,
  input logic [SLOTS-1:0]  wr_addr
);
  logic rsv_page;
  logic access_nz;
  assign rsv_page  = cmd[DW-1];
  assign access_nz = (rd_en || wr_en) && (reg_idx != '0);

  p_cmd_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == '0) |=> (cmd == $past(wr_data)));

  p_cmd_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == '0) |-> (rd_data == cmd));

  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_cmd, wr_local, wr_addr}));

  p_txcnt_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd[DW-1 -: 2] == 2'd0 && reg_idx == IW'(5)) |=>
    (tx_count[DW-1:0] == $past(wr_data) &&
     tx_count[2*DW-1:DW] == $past(tx_count[2*DW-1:DW])));

  p_txcnt_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd[DW-1 -: 2] == 2'd0 && reg_idx == IW'(6)) |=>
    (tx_count[2*DW-1:DW] == $past(wr_data) &&
     tx_count[DW-1:0] == $past(tx_count[DW-1:0])));

  p_rsv_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_page && reg_idx != '0) |-> (rd_data == '0));

  p_rsv_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_page && wr_en && reg_idx != '0) |=> $stable(tx_count));

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_page && access_nz) |=> page_err);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsv_page && access_nz) |=> !page_err);
endmodule

bind nic_reg_bank nicreg_checker #(.DW(DW), .IW(IW), .SLOTS(SLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_idx  (reg_idx),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .page_err (page_err),
  .cmd      (cmd),
  .tx_count (tx_count),
  .wr_cmd   (wr_cmd),
  .wr_local (wr_local),
  .wr_addr  (wr_addr)
);

// File: tb/sim_nic_reg_bank.sv
`timescale 1ns/1ps
module sim_nic_reg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        page_err;
  logic [7:0]  cmd, ring_start, ring_stop, boundary, tx_page, int_status;
  logic [15:0] tx_count, remote_addr, remote_count;
  logic [7:0]  rx_cfg, tx_cfg, data_cfg, int_mask, cur_page_ptr;
  logic [47:0] station_addr;
  logic [63:0] mcast_filter;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_cmd;
  logic [7:0] m_loc [16];
  logic [7:0] m_adr [16];

  always #4 clk = ~clk;

  nic_reg_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .page_err(page_err), .cmd(cmd), .ring_start(ring_start),
    .ring_stop(ring_stop), .boundary(boundary), .tx_page(tx_page),
    .tx_count(tx_count), .int_status(int_status),
    .remote_addr(remote_addr), .remote_count(remote_count),
    .rx_cfg(rx_cfg), .tx_cfg(tx_cfg), .data_cfg(data_cfg),
    .int_mask(int_mask), .station_addr(station_addr),
    .cur_page_ptr(cur_page_ptr), .mcast_filter(mcast_filter)
  );

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] pg, input int i);
    if (i == 0)  return m_cmd;
    if (pg == 0) return (i == 3 || i == 7) ? m_loc[i] : 8'h00;
    if (pg == 1) return m_adr[i];
    return 8'h00;
  endfunction

  // Write: strobe from one negedge to the next; the posedge between captures it.
  task automatic wr(input int i, input logic [7:0] d);
    @(negedge clk);
    reg_idx = 4'(i); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (i == 0) m_cmd = d;
    else if (m_cmd[7:6] == 2'd0) m_loc[i] = d;
    else if (m_cmd[7:6] == 2'd1) m_adr[i] = d;
    chk((m_cmd[7:6] >= 2 && i != 0) ? "R8 err pulse" : "R9 no err",
        64'(page_err), 64'(m_cmd[7:6] >= 2 && i != 0));
  endtask

  task automatic rd_check(input int i, input string req);
    @(negedge clk);
    reg_idx = 4'(i);
    #1;
    chk(req, 64'(rd_data), 64'(exp_rd(m_cmd[7:6], i)));
  endtask

  task automatic check_outputs(input string req);
    chk({req, " cmd"},        64'(cmd),          64'(m_cmd));
    chk({req, " ring_start"}, 64'(ring_start),   64'(m_loc[1]));
    chk({req, " ring_stop"},  64'(ring_stop),    64'(m_loc[2]));
    chk({req, " boundary"},   64'(boundary),     64'(m_loc[3]));
    chk({req, " tx_page"},    64'(tx_page),      64'(m_loc[4]));
    chk({req, " tx_count"},   64'(tx_count),     64'({m_loc[6], m_loc[5]}));
    chk({req, " int_status"}, 64'(int_status),   64'(m_loc[7]));
    chk({req, " remote_addr"},64'(remote_addr),  64'({m_loc[9], m_loc[8]}));
    chk({req, " remote_cnt"}, 64'(remote_count), 64'({m_loc[11], m_loc[10]}));
    chk({req, " rx_cfg"},     64'(rx_cfg),       64'(m_loc[12]));
    chk({req, " tx_cfg"},     64'(tx_cfg),       64'(m_loc[13]));
    chk({req, " data_cfg"},   64'(data_cfg),     64'(m_loc[14]));
    chk({req, " int_mask"},   64'(int_mask),     64'(m_loc[15]));
    chk({req, " cur_page"},   64'(cur_page_ptr), 64'(m_adr[7]));
    for (int j = 0; j < 6; j++)
      chk({req, " station"}, 64'(station_addr[j*8 +: 8]), 64'(m_adr[1+j]));
    for (int j = 0; j < 8; j++)
      chk({req, " filter"}, 64'(mcast_filter[j*8 +: 8]), 64'(m_adr[8+j]));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_cmd = 8'h01;
    for (int i = 0; i < 16; i++) begin m_loc[i] = 8'h00; m_adr[i] = 8'h00; end
    m_loc[7] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: power-up values
    chk("R2 cmd reset", 64'(cmd), 64'h01);
    chk("R2 int_status reset", 64'(int_status), 64'h80);
    check_outputs("R2");
    rd_check(0, "R2 read cmd");
    rd_check(7, "R2 read int_status");

    // Sweep: write all indices on every page, then read every page.
    for (int p = 0; p < 4; p++) begin
      wr(0, {2'(p), 6'b000010});
      chk("R1 cmd write", 64'(cmd), 64'({2'(p), 6'b000010}));
      rd_check(0, "R1 cmd read");
      for (int i = 1; i < 16; i++)
        wr(i, 8'(p * 61 + i * 13 + 8'h17));
      check_outputs(p >= 2 ? "R8 ignored write" : "R3 R5 R7 outputs");
      for (int q = 0; q < 4; q++) begin
        wr(0, {2'(q), 6'b101001});
        for (int i = 0; i < 16; i++)
          rd_check(i, q == 0 ? "R4 local read" :
                      q == 1 ? "R5 addr read" : "R8 rsv read");
      end
    end

    // R6: byte-split transmit count
    wr(0, 8'h00);
    wr(5, 8'h34);
    chk("R6 tx lo", 64'(tx_count), 64'({m_loc[6], 8'h34}));
    wr(6, 8'h12);
    chk("R6 tx hi", 64'(tx_count), 64'h1234);
    wr(5, 8'hCD);
    chk("R6 tx lo keeps hi", 64'(tx_count), 64'h12CD);
    wr(9, 8'hA0);
    chk("R6 remote addr hi", 64'(remote_addr), 64'({8'hA0, m_loc[8]}));

    // R9/R8: read strobes and the error pulse
    for (int p = 0; p < 4; p++) begin
      wr(0, {2'(p), 6'b0});
      for (int i = 0; i < 2; i++) begin
        @(negedge clk);
        reg_idx = 4'(i * 4); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk((p >= 2 && i != 0) ? "R8 read err" : "R9 read no err",
            64'(page_err), 64'(p >= 2 && i != 0));
        @(negedge clk);
        chk("R8 err one cycle", 64'(page_err), 64'h0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule